// File: doc/BRIEF.md
# Column Row Readout Serializer

This block takes one row of single-bit photon-detect results from a column-parallel readout and drives it off the die over a fixed set of serial lanes. Each column bit is 1 when the pixel saw an avalanche during its exposure and 0 otherwise. A one-cycle sample strobe captures the whole column bus into a holding buffer. The row then moves into a lane shifter. With the default 128 columns and 16 lanes, each lane sends 8 columns, one bit per clock, so a full row leaves in 8 clocks at 16 bits per clock.

There are two row buffers: the holding buffer and the lane shifter. Because of this, the next row can be sampled while the previous one is still shifting. Rows that are held back this way go out with no idle cycle between them. A row-valid output tells the receiver which cycles carry data. A frame marker tags the first beat of any row that was captured with the first-row input high. If a strobe arrives when both buffers are occupied and the holding buffer is not emptying on that edge, the row is dropped and a sticky overflow flag is raised.

Top module: `rowser_top`

## Requirements
- R1: The row sent out is the column bus value at the clock edge where the strobe was sampled high. Later changes on the column bus do not alter a row that has already been captured.
- R2: On beat j of a row (j = 0 to 7), lane k carries column 8k+j. The lowest column of each group of eight goes first.
- R3: If the strobe is sampled at edge n and the shifter is idle, row-valid is still low after edge n. Beat 0 is present on the lanes from edge n+1 until edge n+2.
- R4: Every row holds row-valid high for exactly 8 consecutive cycles, one beat per cycle.
- R5: The frame marker is high only on beat 0 of a row whose first-row input was high at capture. It is low on all other cycles.
- R6: A strobe is accepted while a row is shifting if the holding buffer is empty or is emptying on that edge. Accepted rows come out in capture order, and a held row starts on the cycle right after the previous row's last beat.
- R7: A strobe sampled while the holding buffer is full and not emptying on that edge is dropped. The dropped row never appears on the lanes. The overflow output goes high after that edge and stays high until reset.
- R8: While row-valid is low, all 16 lanes are 0.
- R9: A synchronous active-high reset empties both buffers, so a row captured before reset never comes out. It also clears overflow and forces row-valid and the frame marker low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| col_bus | input | 128 | One photon-detect bit per column |
| sample_stb | input | 1 | Capture the column bus into the holding buffer |
| row_first | input | 1 | Marks the captured row as the first row of a frame |
| lane_data | output | 16 | Serial lane outputs, one bit per lane per clock |
| row_valid | output | 1 | High on every cycle that carries a row beat |
| frame_mark | output | 1 | High on beat 0 of a frame's first row |
| overflow | output | 1 | Sticky flag for a dropped row |

## Verification
The hardest case to reach is the single edge where the holding buffer is full and, on that same edge, hands its row to the shifter while a new strobe arrives. That strobe must be accepted, but one cycle later an identical strobe must be dropped. The bench reaches this by pulsing the strobe on three consecutive cycles from idle. It then expects exactly two rows, sent without a gap, followed by a raised overflow flag. Randomised rows with random gaps of at least one row length, and random junk on the column bus between strobes, cover capture isolation and the lane mapping.

// File: rtl/rowser_pkg.sv
package rowser_pkg;

    localparam int unsigned DEF_COLS  = 128;
    localparam int unsigned DEF_LANES = 16;

    typedef enum logic {
        SH_IDLE  = 1'b0,
        SH_SHIFT = 1'b1
    } shift_state_e;

    function automatic int unsigned beats_per_row(input int unsigned cols, input int unsigned lanes);
        return cols / lanes;
    endfunction

    function automatic int unsigned beat_width(input int unsigned beats);
        return (beats > 1) ? $clog2(beats) : 1;
    endfunction

endpackage

// File: rtl/rowser_hold.sv
module rowser_hold #(
    parameter int unsigned COLS = rowser_pkg::DEF_COLS
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            stb,
    input  logic [COLS-1:0] bus,
    input  logic            first_in,
    input  logic            take,
    output logic            full,
    output logic [COLS-1:0] data,
    output logic            first_out,
    output logic            drop
);
    logic accept;

    assign accept = stb && (!full || take);
    assign drop   = stb && full && !take;

    always_ff @(posedge clk) begin
        if (rst) begin
            full      <= 1'b0;
            data      <= '0;
            first_out <= 1'b0;
        end else if (accept) begin
            full      <= 1'b1;
            data      <= bus;
            first_out <= first_in;
        end else if (take) begin
            full      <= 1'b0;
        end
    end

endmodule

// File: rtl/rowser_lanes.sv
module rowser_lanes
    import rowser_pkg::*;
#(
    parameter int unsigned COLS  = DEF_COLS,
    parameter int unsigned LANES = DEF_LANES
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [COLS-1:0]  load_bits,
    input  logic             load_first,
    output logic [LANES-1:0] lanes,
    output logic             valid,
    output logic             frame,
    output logic             last
);
    localparam int unsigned BEATS  = beats_per_row(COLS, LANES);
    localparam int unsigned BEAT_W = beat_width(BEATS);
    localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BEATS - 1);

    shift_state_e        state;
    logic [BEAT_W-1:0]   beat;
    logic                first_r;

    assign valid = (state == SH_SHIFT);
    assign last  = valid && (beat == LAST_BEAT);
    assign frame = valid && (beat == '0) && first_r;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= SH_IDLE;
            beat    <= '0;
            first_r <= 1'b0;
        end else if (load) begin
            state   <= SH_SHIFT;
            beat    <= '0;
            first_r <= load_first;
        end else if (valid) begin
            if (beat == LAST_BEAT) begin
                state <= SH_IDLE;
                beat  <= '0;
            end else begin
                beat  <= beat + 1'b1;
            end
        end
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [BEATS-1:0] sr;

        always_ff @(posedge clk) begin
            if (rst) begin
                sr <= '0;
            end else if (load) begin
                sr <= load_bits[g*BEATS +: BEATS];
            end else if (valid) begin
                sr <= sr >> 1;
            end
        end

        assign lanes[g] = valid & sr[0];
    end

endmodule

// File: rtl/rowser_top.sv
module rowser_top
    import rowser_pkg::*;
#(
    parameter int unsigned COLS  = DEF_COLS,
    parameter int unsigned LANES = DEF_LANES
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [COLS-1:0]  col_bus,
    input  logic             sample_stb,
    input  logic             row_first,
    output logic [LANES-1:0] lane_data,
    output logic             row_valid,
    output logic             frame_mark,
    output logic             overflow
);
    logic            hold_full;
    logic [COLS-1:0] hold_data;
    logic            hold_first;
    logic            hold_drop;
    logic            take;
    logic            sh_last;

    // hand the held row over when the shifter is free or finishing its last beat
    assign take = hold_full && (!row_valid || sh_last);

    rowser_hold #(.COLS(COLS)) u_hold (
        .clk       (clk),
        .rst       (rst),
        .stb       (sample_stb),
        .bus       (col_bus),
        .first_in  (row_first),
        .take      (take),
        .full      (hold_full),
        .data      (hold_data),
        .first_out (hold_first),
        .drop      (hold_drop)
    );

    rowser_lanes #(.COLS(COLS), .LANES(LANES)) u_lanes (
        .clk        (clk),
        .rst        (rst),
        .load       (take),
        .load_bits  (hold_data),
        .load_first (hold_first),
        .lanes      (lane_data),
        .valid      (row_valid),
        .frame      (frame_mark),
        .last       (sh_last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            overflow <= 1'b0;
        end else if (hold_drop) begin
            overflow <= 1'b1;
        end
    end

endmodule

// File: rtl/rowser_chk.sv
module rowser_chk #(
    parameter int unsigned LANES = rowser_pkg::DEF_LANES,
    parameter int unsigned BEATS = 8
) (
    input logic             clk,
    input logic             rst,
    input logic [LANES-1:0] lane_data,
    input logic             row_valid,
    input logic             frame_mark,
    input logic             overflow
);
    logic [31:0] run_len;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_len <= '0;
        end else if (row_valid) begin
            run_len <= run_len + 1'b1;
        end else begin
            run_len <= '0;
        end
    end

    // R4: a burst of row-valid is a whole number of rows
    always_ff @(posedge clk) begin
        if (!rst && !row_valid && run_len != 0) begin
            assert_whole_rows_R4: assert ((run_len % BEATS) == 0)
                else $error("row-valid burst of %0d cycles", run_len);
        end
    end

    assert_idle_lanes_zero_R8: assert property (@(posedge clk) disable iff (rst)
        !row_valid |-> (lane_data == '0));

    assert_frame_in_row_R5: assert property (@(posedge clk) disable iff (rst)
        frame_mark |-> row_valid);

    assert_frame_single_R5: assert property (@(posedge clk) disable iff (rst)
        frame_mark |=> !frame_mark);

    assert_overflow_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        overflow |=> overflow);

    assert_reset_clears_R9: assert property (@(posedge clk)
        rst |=> (!row_valid && !overflow && !frame_mark));

endmodule

bind rowser_top rowser_chk #(
    .LANES (LANES),
    .BEATS (COLS / LANES)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .lane_data  (lane_data),
    .row_valid  (row_valid),
    .frame_mark (frame_mark),
    .overflow   (overflow)
);

// File: tb/rowser_top_tb.sv
`timescale 1ns/1ps
module rowser_top_tb;
    localparam int COLS  = 128;
    localparam int LANES = 16;
    localparam int BEATS = COLS / LANES;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [COLS-1:0]  col_bus = '0;
    logic             sample_stb = 1'b0;
    logic             row_first = 1'b0;
    logic [LANES-1:0] lane_data;
    logic             row_valid;
    logic             frame_mark;
    logic             overflow;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    logic [COLS:0] exp_q[$];   // {first, bits}

    always #2.5 clk = ~clk;

    rowser_top u_dut (
        .clk(clk), .rst(rst), .col_bus(col_bus), .sample_stb(sample_stb),
        .row_first(row_first), .lane_data(lane_data), .row_valid(row_valid),
        .frame_mark(frame_mark), .overflow(overflow)
    );

    task automatic check(input bit ok, input string req, input logic [COLS:0] act, input logic [COLS:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [COLS-1:0] rand_row();
        logic [COLS-1:0] r;
        for (int i = 0; i < COLS / 32; i++) r[i*32 +: 32] = $urandom;
        return r;
    endfunction

    function automatic logic [LANES-1:0] beat_of(input logic [COLS-1:0] r, input int j);
        logic [LANES-1:0] b;
        for (int k = 0; k < LANES; k++) b[k] = r[k*BEATS + j];
        return b;
    endfunction

    // monitor: rebuild rows from lanes and compare against the expected queue
    int            mbeat = 0;
    logic [COLS-1:0] mrow;
    logic          mfirst;
    always @(negedge clk) begin
        if (rst) begin
            mbeat = 0;
        end else if (row_valid) begin
            if (mbeat == 0) mfirst = frame_mark;
            else check(frame_mark == 1'b0, "R5 frame marker off beat 0", frame_mark, 0);
            for (int k = 0; k < LANES; k++) mrow[k*BEATS + mbeat] = lane_data[k];
            mbeat++;
            if (mbeat == BEATS) begin
                mbeat = 0;
                if (exp_q.size() == 0) begin
                    check(0, "R7 R9 unexpected row", {mfirst, mrow}, 0);
                end else begin
                    logic [COLS:0] e;
                    e = exp_q.pop_front();
                    check({mfirst, mrow} == e, "R1 R2 R5 R6 row content", {mfirst, mrow}, e);
                end
            end
        end else begin
            check(lane_data == '0, "R8 idle lanes", lane_data, 0);
            check(mbeat == 0, "R4 row cut short", mbeat, 0);
            mbeat = 0;
        end
    end

    task automatic strobe_one(input logic [COLS-1:0] d, input logic f, input bit accept);
        @(negedge clk);
        col_bus = d; row_first = f; sample_stb = 1'b1;
        if (accept) exp_q.push_back({f, d});
        @(negedge clk);
        sample_stb = 1'b0; row_first = 1'b0;
        col_bus = rand_row();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            col_bus = rand_row();
        end
    endtask

    initial begin
        void'($urandom(32'h5eed_2024));
        repeat (3) @(negedge clk);
        // R9 reset state
        check(row_valid == 0 && frame_mark == 0 && overflow == 0 && lane_data == 0,
              "R9 reset outputs", {row_valid, frame_mark, overflow, lane_data}, 0);
        rst = 1'b0;
        idle(4);

        // R3 latency and R2 mapping on beat 0
        begin
            logic [COLS-1:0] d;
            d = rand_row();
            @(negedge clk);
            col_bus = d; row_first = 1'b1; sample_stb = 1'b1;
            exp_q.push_back({1'b1, d});
            @(negedge clk);               // after edge n
            check(row_valid == 0, "R3 no output after capture edge", row_valid, 0);
            sample_stb = 1'b0; row_first = 1'b0; col_bus = ~d;
            @(negedge clk);               // after edge n+1
            check(row_valid == 1, "R3 beat 0 after next edge", row_valid, 1);
            check(frame_mark == 1, "R5 frame marker on first row", frame_mark, 1);
            check(lane_data == beat_of(d, 0), "R2 beat 0 lanes", lane_data, beat_of(d, 0));
            @(negedge clk);
            check(lane_data == beat_of(d, 1), "R2 beat 1 lanes", lane_data, beat_of(d, 1));
            idle(12);
        end

        // directed corner rows
        strobe_one('0, 1'b0, 1);
        idle(9);
        strobe_one('1, 1'b0, 1);
        idle(9);

        // random rows with random gaps of at least one row
        for (int r = 0; r < 60; r++) begin
            strobe_one(rand_row(), ($urandom % 4) == 0, 1);
            idle(BEATS - 1 + ($urandom % 5));
        end
        idle(12);

        // R6 accept while shifting, gap of three
        strobe_one(rand_row(), 1'b1, 1);
        idle(2);
        strobe_one(rand_row(), 1'b0, 1);
        idle(20);
        check(overflow == 0, "R6 no overflow when holding buffer free", overflow, 0);

        // R7 burst of three strobes: third dropped, first two back to back
        begin
            logic [COLS-1:0] a, b, c;
            int run;
            a = rand_row(); b = rand_row(); c = rand_row();
            @(negedge clk);
            col_bus = a; sample_stb = 1'b1; exp_q.push_back({1'b0, a});
            @(negedge clk);
            col_bus = b; exp_q.push_back({1'b0, b});
            check(overflow == 0, "R7 no overflow on first strobe", overflow, 0);
            @(negedge clk);
            col_bus = c;
            check(overflow == 0, "R7 no overflow on handover strobe", overflow, 0);
            @(negedge clk);
            sample_stb = 1'b0; col_bus = rand_row();
            check(overflow == 1, "R7 overflow set on drop", overflow, 1);
            run = 0;
            while (row_valid) begin
                run++;
                @(negedge clk);
            end
            check(run == 2 * BEATS - 1, "R6 two rows back to back", run, 2 * BEATS - 1);
            idle(30);
            check(overflow == 1, "R7 overflow sticky", overflow, 1);
        end

        // R9 reset flushes a captured row and clears overflow
        @(negedge clk);
        col_bus = rand_row(); sample_stb = 1'b1;
        @(negedge clk);
        sample_stb = 1'b0; rst = 1'b1;
        idle(2);
        rst = 1'b0;
        idle(25);
        check(overflow == 0, "R9 overflow cleared", overflow, 0);
        check(row_valid == 0, "R9 no row after reset", row_valid, 0);

        check(exp_q.size() == 0, "R6 R7 all accepted rows delivered", exp_q.size(), 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog R4 run did not finish actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule